// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital control side of a successive-approximation converter. A conversion can be requested in two ways: a rising edge on an active-low start pin, or a write of 1 to a software start bit in the control register. Once a request is accepted, the track/hold switches to hold. The conversion is then aligned to the next falling edge of an internal master clock. That master clock is derived from the system clock with a programmable half-period.

The block counts conversion periods and drives BUSY while the conversion runs. When the count ends, it latches the comparator result as a zero-padded word, clears the software start bit, and holds off new requests for a short acquisition window. After reset, a calibration lockout ignores every request for a set number of cycles. The comparator itself is outside this block; its result bits arrive on a stub input.

The reset input is asynchronous active-low and must be deasserted synchronously to `clk`.

Top module: `adc_start_seq`

## Requirements
- R1: While reset is asserted, `busy`, `hold` and `sw_start` are 0 and `result` is 0.
- R2: A cycle in which `conv_n` is 1 and was 0 on the previous clock is a pin request. When an idle block accepts it, `hold` is 1 from the next cycle until `busy` falls.
- R3: A cycle with `ctrl_wr`=1 and `ctrl_start_val`=1 is a software request. When an idle block accepts it, `sw_start` reads 1 from the next cycle.
- R4: The master clock starts low after reset and toggles every `MCLK_HALF` clock cycles, so its first edge is a rising one. `busy` rises on the first master falling edge after a request is accepted, except when the request arrives on a falling edge itself; then the next falling edge is used.
- R5: `busy` stays high for 20 master periods (40·`MCLK_HALF` cycles) if a master rising edge occurs in the acceptance cycle or before the starting falling edge. Otherwise it stays high for 21 periods.
- R6: In the cycle `busy` falls, `result` is loaded with two zero bits above the 14 comparator bits (MSB first); `result` does not change at any other time.
- R7: The falling edge of `busy` clears `sw_start` to 0 and returns `hold` to 0.
- R8: Requests are ignored, not queued, while a request is pending, while `busy` is high, and until two master falling edges have passed after `busy` falls.
- R9: For `CAL_CYCLES` cycles after reset, `cal_active` is 1 and every request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Active-low conversion start pin (rising edge requests) |
| ctrl_wr | input | 1 | Control register write strobe (end of write) |
| ctrl_start_val | input | 1 | Value written to the software start bit |
| comp_bits | input | RES_BITS | Comparator result stub |
| busy | output | 1 | High while a conversion runs |
| hold | output | 1 | Track/hold in hold mode |
| sw_start | output | 1 | Software start bit readback |
| cal_active | output | 1 | Power-up calibration lockout in progress |
| result | output | WORD_BITS | Zero-padded conversion result |

## Verification
The hardest case to reach is a request accepted in the high half of the master clock, after the rising edge has already passed. Only this case takes the 21-period path. A related case is a request that lands in the last cycle of the acquisition window. The bench tracks the master phase itself from the cycle count since reset. Directed starts are placed at every phase offset, and randomly timed pin edges and writes fall at all other offsets. Each cycle is compared with a bench model derived from the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned FAST_PERIODS = 20;
  localparam int unsigned SLOW_PERIODS = 21;
  localparam int unsigned ACQ_PERIODS  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_CONV = 2'd2,
    SQ_ACQ  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mclk_phase.sv
module mclk_phase #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          lvl_q, lvl_d;
  logic          tick;

  assign tick      = (pcnt_q == PW'(HALF - 1));
  assign rise_tick = tick & ~lvl_q;
  assign fall_tick = tick & lvl_q;

  always_comb begin
    pcnt_d = tick ? '0 : pcnt_q + 1'b1;
    lvl_d  = tick ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      lvl_q  <= lvl_d;
    end
  end

  a_r4_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !fall_tick || (HALF == 1));
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int unsigned CYCLES = 900000
) (
  input  logic clk,
  input  logic rst_n,
  output logic cal_active
);
  localparam int unsigned CW = ($clog2(CYCLES + 1) > 0) ? $clog2(CYCLES + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cal_active = (cnt_q != '0);
  assign cnt_en     = cal_active;

  always_comb begin
    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(CYCLES);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  a_r9_lock_releases_once: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_active |=> !cal_active);
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 req_pin,
  input  logic                 req_sw,
  input  logic [RES_BITS-1:0]  comp_bits,
  output logic                 busy,
  output logic                 hold,
  output logic                 sw_start,
  output logic [WORD_BITS-1:0] result
);
  localparam int unsigned PAD = WORD_BITS - RES_BITS;
  localparam int unsigned CW  = $clog2(SLOW_PERIODS + 1);

  seq_state_e           state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 sok_q, sok_d;
  logic                 sw_q, sw_d;
  logic [WORD_BITS-1:0] res_q, res_d;
  logic                 accept;

  assign accept   = (state_q == SQ_IDLE) & (req_pin | req_sw);
  assign busy     = (state_q == SQ_CONV);
  assign hold     = (state_q == SQ_PEND) | (state_q == SQ_CONV);
  assign sw_start = sw_q;
  assign result   = res_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sok_d   = sok_q;
    sw_d    = sw_q;
    res_d   = res_q;
    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_PEND;
          sok_d   = rise_tick;
          if (req_sw) sw_d = 1'b1;
        end
      end
      SQ_PEND: begin
        if (rise_tick) sok_d = 1'b1;
        if (fall_tick) begin
          state_d = SQ_CONV;
          cnt_d   = sok_q ? CW'(FAST_PERIODS) : CW'(SLOW_PERIODS);
          sok_d   = 1'b0;
        end
      end
      SQ_CONV: begin
        if (fall_tick) begin
          if (cnt_q == CW'(1)) begin
            state_d = SQ_ACQ;
            cnt_d   = CW'(ACQ_PERIODS);
            sw_d    = 1'b0;
            res_d   = {{PAD{1'b0}}, comp_bits};
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      default: begin
        if (fall_tick) begin
          if (cnt_q == CW'(1)) state_d = SQ_IDLE;
          else                 cnt_d   = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      sok_q   <= 1'b0;
      sw_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sok_q   <= sok_d;
      sw_q    <= sw_d;
      res_q   <= res_d;
    end
  end

  a_r2_hold_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hold);
  a_r3_sw_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_sw) |=> sw_start);
  a_r4_busy_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall_tick));
  a_r6_result_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(result));
  a_r7_sw_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sw_start && !hold));
  a_r8_no_restart_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !hold);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int unsigned MCLK_HALF  = 2,
  parameter int unsigned CAL_CYCLES = 900000,
  parameter int unsigned RES_BITS   = 14,
  parameter int unsigned WORD_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_n,
  input  logic                 ctrl_wr,
  input  logic                 ctrl_start_val,
  input  logic [RES_BITS-1:0]  comp_bits,
  output logic                 busy,
  output logic                 hold,
  output logic                 sw_start,
  output logic                 cal_active,
  output logic [WORD_BITS-1:0] result
);
  logic pin_q;
  logic pin_rise;
  logic rise_tick, fall_tick;
  logic req_pin, req_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= conv_n;
  end

  assign pin_rise = conv_n & ~pin_q;
  assign req_pin  = pin_rise & ~cal_active;
  assign req_sw   = ctrl_wr & ctrl_start_val & ~cal_active;

  mclk_phase #(.HALF(MCLK_HALF)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  cal_timer #(.CYCLES(CAL_CYCLES)) u_cal (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_active (cal_active)
  );

  conv_fsm #(.RES_BITS(RES_BITS), .WORD_BITS(WORD_BITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .req_pin   (req_pin),
    .req_sw    (req_sw),
    .comp_bits (comp_bits),
    .busy      (busy),
    .hold      (hold),
    .sw_start  (sw_start),
    .result    (result)
  );

  a_r9_cal_stays_track: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |-> (!hold && !sw_start));
endmodule

// File: tb/adc_start_seq_bench.sv
module adc_start_seq_bench;
  localparam int H   = 3;
  localparam int CAL = 40;
  localparam int RB  = 14;
  localparam int WB  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, conv_n, ctrl_wr, ctrl_start_val;
  logic [RB-1:0] comp;
  logic          busy, hold, sw_start, cal_active;
  logic [WB-1:0] result;

  adc_start_seq #(.MCLK_HALF(H), .CAL_CYCLES(CAL), .RES_BITS(RB), .WORD_BITS(WB)) u_adc_start_seq (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .ctrl_wr(ctrl_wr),
    .ctrl_start_val(ctrl_start_val), .comp_bits(comp), .busy(busy), .hold(hold),
    .sw_start(sw_start), .cal_active(cal_active), .result(result)
  );

  int n_run = 0;
  int n_fail = 0;

  int            k;
  bit            m_pend, m_sok, m_busy, m_swb, m_pinq;
  int            m_left, m_acq;
  logic [WB-1:0] m_res;

  function automatic bit is_fall(int kk);
    return (kk % H == H - 1) && ((kk / H) % 2 == 1);
  endfunction
  function automatic bit is_rise(int kk);
    return (kk % H == H - 1) && ((kk / H) % 2 == 0);
  endfunction
  function automatic bit m_idle();
    return !m_pend && !m_busy && (m_acq == 0) && !(k < CAL);
  endfunction
  function automatic logic [WB-1:0] padded(logic [RB-1:0] v);
    return {{(WB-RB){1'b0}}, v};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic model_step();
    bit f, r, pr, sw, req;
    f  = is_fall(k);
    r  = is_rise(k);
    pr = conv_n && !m_pinq;
    sw = ctrl_wr && ctrl_start_val;
    req = (pr || sw) && m_idle();
    if (f) begin
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy = 0; m_res = padded(comp); m_acq = 2; m_swb = 0;
        end else m_left--;
      end else if (m_acq > 0) m_acq--;
      if (m_pend) begin
        m_busy = 1; m_left = m_sok ? 20 : 21; m_pend = 0; m_sok = 0;
      end
    end
    if (r && m_pend) m_sok = 1;
    if (req) begin
      m_pend = 1; m_sok = r;
      if (sw) m_swb = 1;
    end
    m_pinq = conv_n;
    k++;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R4 R5 R8 R9 busy", busy, m_busy);
    check("R2 R8 R9 hold", hold, m_pend || m_busy);
    check("R3 R7 sw_start", sw_start, m_swb);
    check("R6 result", result, m_res);
    check("R9 cal_active", cal_active, k < CAL);
  endtask

  task automatic measure(int ph, bit use_pin, int expn, logic [RB-1:0] val);
    int cnt;
    bit seen;
    cnt = 0; seen = 0;
    conv_n = 1'b0;
    cyc();
    while (!m_idle() || (k % (2*H)) != ph) cyc();
    comp = val;
    if (use_pin) conv_n = 1'b1;
    else begin ctrl_wr = 1'b1; ctrl_start_val = 1'b1; end
    cyc();
    ctrl_wr = 1'b0;
    if (!use_pin) check("R3 sw bit set by write", sw_start, 1);
    for (int i = 0; i < 400; i++) begin
      cyc();
      if (busy) begin cnt++; seen = 1; end
      else if (seen) break;
    end
    check("R5 conversion length", cnt, expn * 2 * H);
    check("R6 padded result", result, padded(val));
    check("R7 sw bit cleared", sw_start, 0);
  endtask

  task automatic probe_r8();
    conv_n = 1'b0;
    cyc();
    while (!m_idle()) cyc();
    conv_n = 1'b1;
    cyc();
    repeat (2*H + 2) cyc();
    ctrl_wr = 1'b1; ctrl_start_val = 1'b1;
    cyc();
    ctrl_wr = 1'b0;
    check("R8 write during busy ignored", sw_start, 0);
    conv_n = 1'b0;
    while (!busy) cyc();
    while (busy) cyc();
    conv_n = 1'b1;
    cyc();
    check("R8 pin edge in acquisition ignored", hold, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    rst_n = 1'b0; conv_n = 1'b1; ctrl_wr = 1'b0; ctrl_start_val = 1'b0; comp = '0;
    m_pend = 0; m_sok = 0; m_busy = 0; m_swb = 0; m_pinq = 1;
    m_left = 0; m_acq = 0; m_res = '0; k = 0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset hold", hold, 0);
    check("R1 reset sw_start", sw_start, 0);
    check("R1 reset result", result, 0);
    rst_n = 1'b1;

    repeat (4) cyc();
    ctrl_wr = 1'b1; ctrl_start_val = 1'b1;
    cyc();
    ctrl_wr = 1'b0;
    check("R9 write during calibration", sw_start, 0);
    conv_n = 1'b0; cyc();
    conv_n = 1'b1; cyc();
    check("R9 pin during calibration", hold, 0);
    while (k < CAL) cyc();

    measure(3, 1'b1, 21, 14'h2A5C);
    measure(4, 1'b0, 21, 14'h3FFF);
    measure(2, 1'b1, 20, 14'h0001);
    measure(0, 1'b0, 20, 14'h1234);
    measure(5, 1'b1, 20, 14'h2000);
    measure(1, 1'b0, 20, 14'h0F0F);
    probe_r8();

    repeat (3000) begin
      if ($urandom % 8 == 0) conv_n = ~conv_n;
      ctrl_wr        = ($urandom % 25 == 0);
      ctrl_start_val = $urandom % 2;
      comp           = RB'($urandom);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule